// File: doc/BRIEF.md
# Sub-word register write coalescing bridge

This block connects a host bus that issues byte, halfword and word register accesses to a register file that only understands aligned 32-bit reads and writes. Narrow reads become one aligned word read, and the addressed lane is returned zero-extended. Narrow writes become a read-modify-write of the aligned word, with one exception: the halfwords that set block size, block count and transfer mode are kept in two shadow words inside the bridge. They are sent to the register file only when the command halfword is written.

On a command write, a non-empty block shadow goes out first as a single word, and the block shadow is then cleared. The command word follows, made of the transfer mode plus the new command. Two halves of the same word are therefore never written to the register file in close succession. The register file's card-side logic has trouble with such writes when the card clock is slow.

When the programmed card clock is at or below 400 kHz, the bridge waits after every downstream write for a time equal to four card clocks, rounded up to whole microseconds, before it proceeds. The host sees `h_ready` low for the whole of each operation.

Top module: `narrow_reg_bridge`

## Requirements
- R1: Every downstream access uses the host address with bits [1:0] forced to zero; the lane shift is 8 times the low two address bits.
- R2: A read returns, zero-extended on `h_rdata` with a one-cycle `h_rvalid` pulse, the lane selected by `h_size` (0 = byte, 1 = halfword, 2 = word) at the lane shift, taken from one downstream word read.
- R3: A byte write reads the aligned word, replaces only the addressed byte and writes the word back; the other three bytes keep their values.
- R4: A halfword write to offset 0x04 or 0x06 updates the low or high half of the block shadow and causes no downstream access.
- R5: A halfword write to offset 0x0C updates the low half of the command shadow and causes no downstream access.
- R6: A halfword write to offset 0x0E while the block shadow is non-zero produces exactly two downstream writes. The first writes the block shadow to 0x04. The second writes the command shadow, with the new value in its upper half, to 0x0C. The block shadow then reads as zero.
- R7: A halfword write to offset 0x0E while the block shadow is zero produces exactly one downstream write, to 0x0C.
- R8: A halfword write to any other offset is a read-modify-write that replaces only the addressed half.
- R9: A word write goes straight downstream and leaves both shadows unchanged.
- R10: When 0 < `card_hz` <= 400000, every downstream write is followed by a quiet gap of ceil(4000000 / `card_hz`) microseconds, one microsecond being `US_CYCLES` clocks, before the next step. No gap is inserted for faster clocks or for `card_hz` = 0.
- R11: Reset leaves `h_ready` high, `d_req` low and both shadows zero. `h_ready` is low, and new requests are not taken, while an operation or gap is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_hz | input | FREQ_W | Card clock frequency in Hz |
| h_req | input | 1 | Host request, taken when `h_ready` is high |
| h_we | input | 1 | Host write (1) or read (0) |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| h_addr | input | AW | Host byte address |
| h_wdata | input | 32 | Host write data, lane-aligned at bit 0 |
| h_ready | output | 1 | Bridge idle and able to take a request |
| h_rvalid | output | 1 | One-cycle pulse with read data |
| h_rdata | output | 32 | Zero-extended read result |
| d_req | output | 1 | Downstream request, held until acknowledged |
| d_we | output | 1 | Downstream write (1) or read (0) |
| d_addr | output | AW | Aligned downstream address |
| d_wdata | output | 32 | Downstream write word |
| d_rdata | input | 32 | Downstream read word, valid with `d_ack` |
| d_ack | input | 1 | Downstream acknowledge |

## Verification
The bench checks that the downstream write log holds the block word before the command word, and that a second command write produces only a single write. A design that failed to clear the block shadow would replay the stale block word. The bench also watches byte and halfword writes at lanes 1 and 3 and at the upper half. A wrong shift or mask would show up there as a clobbered neighbour byte. The quiet gap is timed by counting the cycles `h_ready` stays low at 300 kHz, at exactly 400 kHz, just above 400 kHz and at zero. An off-by-one limit or a truncating division would lengthen or shorten that count by whole microseconds.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_BLK,
    ST_CMD,
    ST_SETTLE
  } seq_state_e;

  localparam int unsigned OFS_BLKSZ  = 32'h04;
  localparam int unsigned OFS_BLKCNT = 32'h06;
  localparam int unsigned OFS_MODE   = 32'h0C;
  localparam int unsigned OFS_CMD    = 32'h0E;

  localparam int unsigned SLOW_HZ_MAX  = 400000;
  localparam int unsigned GAP_BUDGET   = 4000000;

  function automatic logic [4:0] lane_shift(logic [1:0] lsb, logic [1:0] sz);
    logic [4:0] sh;
    sh = (sz == SZ_WORD) ? 5'd0 : {lsb, 3'b000};
    return sh;
  endfunction

  function automatic logic [31:0] lane_field(logic [1:0] sz);
    logic [31:0] f;
    case (sz)
      SZ_BYTE: f = 32'h0000_00FF;
      SZ_HALF: f = 32'h0000_FFFF;
      default: f = 32'hFFFF_FFFF;
    endcase
    return f;
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] word, logic [1:0] lsb,
                                             logic [1:0] sz, logic [31:0] wdata);
    logic [31:0] m;
    logic [4:0]  sh;
    sh = lane_shift(lsb, sz);
    m  = lane_field(sz) << sh;
    return (word & ~m) | ((wdata << sh) & m);
  endfunction

endpackage

// File: rtl/sdb_lane_unit.sv
module sdb_lane_unit
  import sdb_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  lsb,
  input  logic [1:0]  sz,
  input  logic [31:0] wdata,
  output logic [31:0] extract,
  output logic [31:0] merged
);
  logic [4:0] sh;

  always_comb begin
    sh      = lane_shift(lsb, sz);
    extract = (word >> sh) & lane_field(sz);
    merged  = lane_merge(word, lsb, sz, wdata);
  end
endmodule

// File: rtl/sdb_shadow_regs.sv
module sdb_shadow_regs
  import sdb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        blk_load,
  input  logic        blk_clear,
  input  logic        cmd_load,
  input  logic [1:0]  lsb,
  input  logic [15:0] half_val,
  output logic [31:0] blk_q,
  output logic [31:0] cmd_q,
  output logic [31:0] cmd_next
);
  logic [31:0] blk_next;

  always_comb begin
    blk_next = lane_merge(blk_q, lsb, SZ_HALF, {16'h0000, half_val});
    cmd_next = lane_merge(cmd_q, lsb, SZ_HALF, {16'h0000, half_val});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
      cmd_q <= '0;
    end else begin
      if (blk_clear)     blk_q <= '0;
      else if (blk_load) blk_q <= blk_next;
      if (cmd_load)      cmd_q <= cmd_next;
    end
  end

  // R6: once the block word has gone downstream the shadow is empty
  assert_blk_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    blk_clear |=> (blk_q == 32'h0));

  // R5: a command-side load never disturbs the block shadow
  assert_cmd_load_keeps_blk_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && !blk_load && !blk_clear) |=> $stable(blk_q));
endmodule

// File: rtl/sdb_settle_timer.sv
module sdb_settle_timer
  import sdb_pkg::*;
#(
  parameter int unsigned US_CYCLES = 200,
  parameter int unsigned FREQ_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] freq,
  input  logic              start,
  output logic              slow,
  output logic              busy,
  output logic              done
);
  localparam int unsigned CW    = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1;
  localparam int unsigned ACC_W = FREQ_W + 1;
  localparam logic [CW-1:0]    CYC_LAST = CW'(US_CYCLES - 1);
  localparam logic [ACC_W-1:0] BUDGET   = ACC_W'(GAP_BUDGET);

  logic [CW-1:0]    cyc;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             us_tick;

  always_comb begin
    slow    = (freq != '0) && (freq <= FREQ_W'(SLOW_HZ_MAX));
    us_tick = busy && (cyc == CYC_LAST);
    acc_sum = acc + ACC_W'(freq);
    done    = us_tick && (acc_sum >= BUDGET);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cyc  <= '0;
      acc  <= '0;
    end else if (start && slow) begin
      busy <= 1'b1;
      cyc  <= '0;
      acc  <= '0;
    end else if (busy) begin
      if (us_tick) begin
        cyc <= '0;
        if (done) busy <= 1'b0;
        else      acc  <= acc_sum;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  // R10: a gap is only ever opened for a slow card clock
  assert_gap_only_slow_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(slow));

  // R10: the accumulated budget stays below the limit while waiting
  assert_acc_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (acc < BUDGET));
endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge
  import sdb_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned US_CYCLES = 200,
  parameter int unsigned FREQ_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] card_hz,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [1:0]        h_size,
  input  logic [AW-1:0]     h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_ready,
  output logic              h_rvalid,
  output logic [31:0]       h_rdata,
  output logic              d_req,
  output logic              d_we,
  output logic [AW-1:0]     d_addr,
  output logic [31:0]       d_wdata,
  input  logic [31:0]       d_rdata,
  input  logic              d_ack
);
  localparam logic [AW-1:0] A_BLKSZ   = AW'(OFS_BLKSZ);
  localparam logic [AW-1:0] A_BLKCNT  = AW'(OFS_BLKCNT);
  localparam logic [AW-1:0] A_MODE    = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_CMD     = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_BLKWORD = {A_BLKSZ[AW-1:2], 2'b00};
  localparam logic [AW-1:0] A_CMDWORD = {A_CMD[AW-1:2], 2'b00};

  seq_state_e state;

  logic          op_we;
  logic [1:0]    op_size;
  logic [AW-1:0] op_addr;
  logic [31:0]   op_wdata;
  logic          resume_cmd;

  logic accept, ack, is_half;
  logic a_blk, a_mode, a_cmd;
  logic blk_load, cmd_load, blk_clear, wr_done, settle_start;

  logic [31:0] blk_q, cmd_q, cmd_next;
  logic [31:0] rd_extract, rd_merged;
  logic        slow, settle_busy, settle_done;

  always_comb begin
    accept       = h_ready && h_req;
    ack          = d_req && d_ack;
    is_half      = (h_size == SZ_HALF);
    a_blk        = (h_addr == A_BLKSZ) || (h_addr == A_BLKCNT);
    a_mode       = (h_addr == A_MODE);
    a_cmd        = (h_addr == A_CMD);
    blk_load     = accept && h_we && is_half && a_blk;
    cmd_load     = accept && h_we && is_half && (a_mode || a_cmd);
    blk_clear    = ack && (state == ST_BLK);
    wr_done      = ack && ((state == ST_WR) || (state == ST_CMD) || (state == ST_BLK));
    settle_start = wr_done && slow;
  end

  sdb_shadow_regs u_shadow (
    .clk       (clk),
    .rst       (rst),
    .blk_load  (blk_load),
    .blk_clear (blk_clear),
    .cmd_load  (cmd_load),
    .lsb       (h_addr[1:0]),
    .half_val  (h_wdata[15:0]),
    .blk_q     (blk_q),
    .cmd_q     (cmd_q),
    .cmd_next  (cmd_next)
  );

  sdb_lane_unit u_lane (
    .word    (d_rdata),
    .lsb     (op_addr[1:0]),
    .sz      (op_size),
    .wdata   (op_wdata),
    .extract (rd_extract),
    .merged  (rd_merged)
  );

  sdb_settle_timer #(
    .US_CYCLES (US_CYCLES),
    .FREQ_W    (FREQ_W)
  ) u_settle (
    .clk   (clk),
    .rst   (rst),
    .freq  (card_hz),
    .start (settle_start),
    .slow  (slow),
    .busy  (settle_busy),
    .done  (settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      h_ready    <= 1'b1;
      h_rvalid   <= 1'b0;
      h_rdata    <= '0;
      d_req      <= 1'b0;
      d_we       <= 1'b0;
      d_addr     <= '0;
      d_wdata    <= '0;
      op_we      <= 1'b0;
      op_size    <= '0;
      op_addr    <= '0;
      op_wdata   <= '0;
      resume_cmd <= 1'b0;
    end else begin
      h_rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_we    <= h_we;
            op_size  <= h_size;
            op_addr  <= h_addr;
            op_wdata <= h_wdata;
            if (!h_we) begin
              h_ready <= 1'b0;
              d_req   <= 1'b1;
              d_we    <= 1'b0;
              d_addr  <= {h_addr[AW-1:2], 2'b00};
              state   <= ST_RD;
            end else if (h_size == SZ_WORD) begin
              h_ready <= 1'b0;
              d_req   <= 1'b1;
              d_we    <= 1'b1;
              d_addr  <= {h_addr[AW-1:2], 2'b00};
              d_wdata <= h_wdata;
              state   <= ST_WR;
            end else if (is_half && (a_blk || a_mode)) begin
              state <= ST_IDLE;
            end else if (is_half && a_cmd) begin
              h_ready <= 1'b0;
              d_req   <= 1'b1;
              d_we    <= 1'b1;
              if (blk_q != 32'h0) begin
                d_addr  <= A_BLKWORD;
                d_wdata <= blk_q;
                state   <= ST_BLK;
              end else begin
                d_addr  <= A_CMDWORD;
                d_wdata <= cmd_next;
                state   <= ST_CMD;
              end
            end else begin
              h_ready <= 1'b0;
              d_req   <= 1'b1;
              d_we    <= 1'b0;
              d_addr  <= {h_addr[AW-1:2], 2'b00};
              state   <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (ack) begin
            if (!op_we) begin
              d_req    <= 1'b0;
              h_rdata  <= rd_extract;
              h_rvalid <= 1'b1;
              h_ready  <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              d_we    <= 1'b1;
              d_wdata <= rd_merged;
              state   <= ST_WR;
            end
          end
        end
        ST_WR, ST_CMD: begin
          if (ack) begin
            d_req <= 1'b0;
            d_we  <= 1'b0;
            if (slow) begin
              resume_cmd <= 1'b0;
              state      <= ST_SETTLE;
            end else begin
              h_ready <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        ST_BLK: begin
          if (ack) begin
            if (slow) begin
              d_req      <= 1'b0;
              resume_cmd <= 1'b1;
              state      <= ST_SETTLE;
            end else begin
              d_addr  <= A_CMDWORD;
              d_wdata <= cmd_q;
              state   <= ST_CMD;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            if (resume_cmd) begin
              d_req   <= 1'b1;
              d_we    <= 1'b1;
              d_addr  <= A_CMDWORD;
              d_wdata <= cmd_q;
              state   <= ST_CMD;
            end else begin
              h_ready <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the low address bits never reach the register file
  assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    d_req |-> (d_addr[1:0] == 2'b00));

  // R11: an idle host side means no downstream traffic
  assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    h_ready |-> !d_req);

  // R11: a pending request holds address and direction until acknowledged
  assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_we)));

  // R10: nothing is issued during the quiet gap
  assert_gap_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    settle_busy |-> !d_req);

  // R4: a block-size or block-count halfword produces no downstream request
  assert_blk_no_traffic_R4: assert property (@(posedge clk) disable iff (rst)
    blk_load |=> !d_req);
endmodule

// File: tb/tb_narrow_reg_bridge.sv
`timescale 1ns/1ps
module tb_narrow_reg_bridge;
  localparam int AW  = 8;
  localparam int USC = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] card_hz;
  logic        h_req, h_we;
  logic [1:0]  h_size;
  logic [7:0]  h_addr;
  logic [31:0] h_wdata;
  logic        h_ready, h_rvalid;
  logic [31:0] h_rdata;
  logic        d_req, d_we, d_ack;
  logic [7:0]  d_addr;
  logic [31:0] d_wdata, d_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] mem [0:63];
  logic [7:0]  wl_addr [0:31];
  logic [31:0] wl_data [0:31];
  int          wn = 0;

  always #2.5 clk = ~clk;

  narrow_reg_bridge #(.AW(AW), .US_CYCLES(USC), .FREQ_W(32)) dut (
    .clk(clk), .rst(rst), .card_hz(card_hz),
    .h_req(h_req), .h_we(h_we), .h_size(h_size), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_rdata(d_rdata), .d_ack(d_ack)
  );

  // register file model: one cycle to acknowledge, logs every write
  always @(posedge clk) begin
    if (rst) begin
      d_ack   <= 1'b0;
      d_rdata <= '0;
    end else if (d_req && !d_ack) begin
      d_ack <= 1'b1;
      if (d_we) begin
        mem[d_addr[7:2]] <= d_wdata;
        wl_addr[wn % 32] <= d_addr;
        wl_data[wn % 32] <= d_wdata;
        wn <= wn + 1;
      end else begin
        d_rdata <= mem[d_addr[7:2]];
      end
    end else begin
      d_ack <= 1'b0;
    end
  end

  // {size[41:40], addr[39:32], expected[31:0]}; word 0x10 = A1B2C3D4, 0x14 = 55667788
  localparam logic [41:0] RD_VEC [0:7] = '{
    {2'd0, 8'h10, 32'h0000_00D4},
    {2'd0, 8'h11, 32'h0000_00C3},
    {2'd0, 8'h13, 32'h0000_00A1},
    {2'd1, 8'h10, 32'h0000_C3D4},
    {2'd1, 8'h12, 32'h0000_A1B2},
    {2'd2, 8'h10, 32'hA1B2_C3D4},
    {2'd0, 8'h16, 32'h0000_0066},
    {2'd1, 8'h16, 32'h0000_5566}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int low);
    low = 0;
    rd  = '0;
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_req = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
    @(negedge clk);
    h_req = 1'b0;
    while (!h_ready) begin
      low++;
      @(negedge clk);
    end
    if (h_rvalid) rd = h_rdata;
  endtask

  function automatic int exp_low(input int hz);
    if (hz > 0 && hz <= 400000) return 2 + ((4000000 + hz - 1) / hz) * USC;
    return 2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int low, w0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[4] = 32'hA1B2_C3D4;
    mem[5] = 32'h5566_7788;
    mem[8] = 32'h1234_5678;
    rst = 1'b1; h_req = 1'b0; h_we = 1'b0; h_size = 2'd0; h_addr = '0; h_wdata = '0;
    card_hz = 32'd25_000_000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset ready", {31'b0, h_ready}, 32'd1);
    chk("R11 reset d_req", {31'b0, d_req}, 32'd0);
    chk("R11 reset rvalid", {31'b0, h_rvalid}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      access(1'b0, RD_VEC[i][41:40], RD_VEC[i][39:32], 32'h0, rd, low);
      chk("R2 read lane", rd, RD_VEC[i][31:0]);
    end
    chk("R11 busy during read", low, 2);

    w0 = wn;
    access(1'b1, 2'd0, 8'h11, 32'h0000_00EE, rd, low);
    chk("R3 byte lane1 merge", mem[4], 32'hA1B2_EED4);
    chk("R1 aligned write addr", {24'h0, wl_addr[w0 % 32]}, 32'h10);
    access(1'b1, 2'd0, 8'h13, 32'h0000_005A, rd, low);
    chk("R3 byte lane3 merge", mem[4], 32'h5AB2_EED4);

    access(1'b1, 2'd1, 8'h22, 32'h0000_BEEF, rd, low);
    chk("R8 upper half rmw", mem[8], 32'hBEEF_5678);

    w0 = wn;
    access(1'b1, 2'd2, 8'h04, 32'hDEAD_BEEF, rd, low);
    chk("R9 word passthrough", mem[1], 32'hDEAD_BEEF);
    chk("R9 one write", wn - w0, 1);
    w0 = wn;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0011, rd, low);
    chk("R7 single cmd write", wn - w0, 1);
    chk("R7 cmd addr", {24'h0, wl_addr[w0 % 32]}, 32'h0C);
    chk("R9 shadows untouched", wl_data[w0 % 32], 32'h0011_0000);

    w0 = wn;
    access(1'b1, 2'd1, 8'h04, 32'h0000_0200, rd, low);
    access(1'b1, 2'd1, 8'h06, 32'h0000_0003, rd, low);
    chk("R4 no downstream write", wn - w0, 0);
    chk("R4 block word unchanged", mem[1], 32'hDEAD_BEEF);
    access(1'b1, 2'd1, 8'h0C, 32'h0000_0025, rd, low);
    chk("R5 no downstream write", wn - w0, 0);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_1234, rd, low);
    chk("R6 two writes", wn - w0, 2);
    chk("R6 first addr", {24'h0, wl_addr[w0 % 32]}, 32'h04);
    chk("R6 first data", wl_data[w0 % 32], 32'h0003_0200);
    chk("R6 second addr", {24'h0, wl_addr[(w0 + 1) % 32]}, 32'h0C);
    chk("R6 second data", wl_data[(w0 + 1) % 32], 32'h1234_0025);
    w0 = wn;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0001, rd, low);
    chk("R6 shadow cleared", wn - w0, 1);
    chk("R6 mode kept", wl_data[w0 % 32], 32'h0001_0025);

    card_hz = 32'd300000;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0002, rd, low);
    chk("R10 gap 300k", low, exp_low(300000));
    card_hz = 32'd400000;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0002, rd, low);
    chk("R10 gap 400k", low, exp_low(400000));
    card_hz = 32'd400001;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0002, rd, low);
    chk("R10 no gap above", low, 2);
    card_hz = 32'd0;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0002, rd, low);
    chk("R10 no gap at zero", low, 2);

    card_hz = 32'd400000;
    access(1'b1, 2'd1, 8'h06, 32'h0000_0001, rd, low);
    w0 = wn;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0003, rd, low);
    chk("R10 two gaps", low, 2 * exp_low(400000));
    chk("R6 slow first data", wl_data[w0 % 32], 32'h0001_0000);
    chk("R6 slow second data", wl_data[(w0 + 1) % 32], 32'h0003_0025);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule